// File: doc/BRIEF.md
# Three-Channel Skew Realigner

This block receives three decoded video channels. Each channel's words arrive in the internal clock domain with their own valid strobe and data-enable flag, and each channel may be offset from the others by a few words because it was recovered on a different sampling phase. Every channel feeds its own small FIFO. A controller pops the three FIFOs in lockstep, so that each output word carries the same pixel from all three channels.

Alignment uses the start of active video on each line. This is the first word with DE high after one or more words with DE low, and it is called the line marker here. A channel whose marker reaches its FIFO head first is held. The other channels drop blanking words until their own markers arrive, and then all three advance together. The offsets found on the first line after reset are checked again on every later line. If the markers of one line are spread further apart than a set window, an error pulse is raised and the alignment is captured again on that line.

Top module: `skew_realign_top`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `valid_o`, `de_o` and `align_err_o` are low.
- R2: Every output word with `valid_o` and `de_o` high carries the same pixel from all three channels, and active pixels come out in input order with none lost or repeated. In `data_o`, channel 0 sits in bits [DATA_W-1:0], channel 1 in the next DATA_W bits, and channel 2 in the top DATA_W bits.
- R3: After reset, nothing is output until every channel has presented a line marker, which is a word with DE high that follows a word with DE low. Words before the marker are discarded, including active words seen before any blanking.
- R4: On a line after the first, if the markers reach the FIFO heads at most SKEW_MAX (default 2) words apart relative to the current alignment, the block realigns without raising `align_err_o`. It does this by holding the leading channels and dropping the blanking words of the lagging channels.
- R5: If a lagging marker is more than SKEW_MAX words behind, `align_err_o` is high for exactly one cycle before the first active word of that line. The block recaptures alignment on that same line, so the line's pixels still come out aligned (R2), provided the offset fits in the FIFOs.
- R6: `de_o` is high only when all three channels have DE high in that aligned word. A word in which any channel has DE low is output with `valid_o` high and `de_o` low.
- R7: A channel word is accepted only in a cycle when its valid strobe is high. Idle cycles add no word and drop none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch0_valid_i | input | 1 | Channel 0 word strobe |
| ch0_data_i | input | DATA_W | Channel 0 decoded word |
| ch0_de_i | input | 1 | Channel 0 data enable |
| ch1_valid_i | input | 1 | Channel 1 word strobe |
| ch1_data_i | input | DATA_W | Channel 1 decoded word |
| ch1_de_i | input | 1 | Channel 1 data enable |
| ch2_valid_i | input | 1 | Channel 2 word strobe |
| ch2_data_i | input | DATA_W | Channel 2 decoded word |
| ch2_de_i | input | 1 | Channel 2 data enable |
| valid_o | output | 1 | Aligned word present |
| de_o | output | 1 | Common data enable |
| data_o | output | 3*DATA_W | Aligned words {ch2, ch1, ch0} |
| align_err_o | output | 1 | One-cycle pulse: marker spread exceeded SKEW_MAX |

## Verification
If the controller holds the wrong channel or discards one word too many, the three pixel tags in the very next active output word disagree. The bench encodes a line number and pixel index in every word, so it catches this on the first affected word. A broken spread counter shows up as a missing or extra error pulse, which the bench checks just before the first pixel of each line. A wrong data-enable combination shows up on the deliberately shortened lines, where one word must come out with `de_o` low.

// File: rtl/skew_realign_pkg.sv
package skew_realign_pkg;
  localparam int unsigned NUM_CH = 3;

  typedef enum logic {
    ST_SEEK = 1'b0,
    ST_LOCK = 1'b1
  } align_state_e;
endpackage

// File: rtl/skew_fifo.sv
module skew_fifo #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 16  // power of two
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] rdata_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW:0]   cnt_q;
  logic          full, do_push, do_pop;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full;  // word dropped when full
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/skew_lane.sv
module skew_lane #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              de_i,
  input  logic              pop_i,
  output logic              avail_o,
  output logic              mark_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_de_o
);
  logic              empty;
  logic [DATA_W:0]   head;
  logic              last_de_q;

  skew_fifo #(.W(DATA_W + 1), .DEPTH(DEPTH)) fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (valid_i),
    .wdata_i ({de_i, data_i}),
    .pop_i   (pop_i),
    .empty_o (empty),
    .rdata_o (head)
  );

  assign head_de_o   = head[DATA_W];
  assign head_data_o = head[DATA_W-1:0];
  assign avail_o     = !empty;

  // Reset to 1: a line already active at reset yields no marker
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_de_q <= 1'b1;
    else if (pop_i) last_de_q <= head_de_o;
  end

  assign mark_o = avail_o && head_de_o && !last_de_q;
endmodule

// File: rtl/skew_align_ctrl.sv
module skew_align_ctrl
  import skew_realign_pkg::*;
#(
  parameter int unsigned NCH      = NUM_CH,
  parameter int unsigned SKEW_MAX = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] avail_i,
  input  logic [NCH-1:0] mark_i,
  output logic [NCH-1:0] pop_o,
  output logic           emit_o,
  output logic           err_o
);
  localparam int unsigned CNT_W = (SKEW_MAX < 1) ? 1 : $clog2(SKEW_MAX + 1);

  align_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic err_q, err_d;
  logic any_mark, all_mark, all_avail;

  assign any_mark  = |mark_i;
  assign all_mark  = &mark_i;
  assign all_avail = &avail_i;

  always_comb begin
    pop_o   = '0;
    emit_o  = 1'b0;
    err_d   = 1'b0;
    cnt_d   = cnt_q;
    state_d = state_q;
    if (all_mark) begin
      pop_o   = '1;
      emit_o  = 1'b1;
      cnt_d   = '0;
      state_d = ST_LOCK;
    end else if (state_q == ST_LOCK && !any_mark) begin
      if (all_avail) begin
        pop_o  = '1;
        emit_o = 1'b1;
      end
    end else begin
      // hunt: hold marked heads, drop the rest
      for (int k = 0; k < NCH; k++) pop_o[k] = avail_i[k] && !mark_i[k];
      if (state_q == ST_LOCK && |pop_o) begin
        if (cnt_q == CNT_W'(SKEW_MAX)) begin
          err_d   = 1'b1;
          cnt_d   = '0;
          state_d = ST_SEEK;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEEK;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  assign err_o = err_q;

  p_emit_all_avail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_o |-> all_avail);
  p_err_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q);
  p_err_from_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (state_q == ST_SEEK && $past(state_q) == ST_LOCK));
endmodule

// File: rtl/skew_realign_top.sv
module skew_realign_top
  import skew_realign_pkg::*;
#(
  parameter int unsigned DATA_W     = 10,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned SKEW_MAX   = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ch0_valid_i,
  input  logic [DATA_W-1:0]     ch0_data_i,
  input  logic                  ch0_de_i,
  input  logic                  ch1_valid_i,
  input  logic [DATA_W-1:0]     ch1_data_i,
  input  logic                  ch1_de_i,
  input  logic                  ch2_valid_i,
  input  logic [DATA_W-1:0]     ch2_data_i,
  input  logic                  ch2_de_i,
  output logic                  valid_o,
  output logic                  de_o,
  output logic [3*DATA_W-1:0]   data_o,
  output logic                  align_err_o
);
  localparam int unsigned NCH   = NUM_CH;
  localparam int unsigned OUT_W = NCH * DATA_W;

  logic [NCH-1:0]    in_valid, in_de;
  logic [DATA_W-1:0] in_data [NCH];
  logic [NCH-1:0]    avail, mark, pop, head_de;
  logic [OUT_W-1:0]  head_bus;
  logic              emit;

  assign in_valid   = {ch2_valid_i, ch1_valid_i, ch0_valid_i};
  assign in_de      = {ch2_de_i, ch1_de_i, ch0_de_i};
  assign in_data[0] = ch0_data_i;
  assign in_data[1] = ch1_data_i;
  assign in_data[2] = ch2_data_i;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    skew_lane #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) lane_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .valid_i     (in_valid[g]),
      .data_i      (in_data[g]),
      .de_i        (in_de[g]),
      .pop_i       (pop[g]),
      .avail_o     (avail[g]),
      .mark_o      (mark[g]),
      .head_data_o (head_bus[g*DATA_W +: DATA_W]),
      .head_de_o   (head_de[g])
    );
  end

  skew_align_ctrl #(.NCH(NCH), .SKEW_MAX(SKEW_MAX)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .avail_i (avail),
    .mark_i  (mark),
    .pop_o   (pop),
    .emit_o  (emit),
    .err_o   (align_err_o)
  );

  logic             valid_q, de_q;
  logic [OUT_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      de_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= emit;
      de_q    <= emit && (&head_de);
      if (emit) data_q <= head_bus;
    end
  end

  assign valid_o = valid_q;
  assign de_o    = de_q;
  assign data_o  = data_q;
endmodule

// File: tb/skew_realign_top_tb_top.sv
module skew_realign_top_tb_top;
  localparam int W        = 10;
  localparam int SKEW_MAX = 2;
  localparam int MAXD     = 3;
  localparam int NLINES   = 40;
  localparam logic [W-1:0] BLANK = {4'd15, 6'd0};

  logic clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  logic rst_ni;
  logic ch0_valid_i, ch1_valid_i, ch2_valid_i;
  logic ch0_de_i, ch1_de_i, ch2_de_i;
  logic [W-1:0] ch0_data_i, ch1_data_i, ch2_data_i;
  logic valid_o, de_o, align_err_o;
  logic [3*W-1:0] data_o;

  skew_realign_top #(.DATA_W(W), .FIFO_DEPTH(16), .SKEW_MAX(SKEW_MAX)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ch0_valid_i(ch0_valid_i), .ch0_data_i(ch0_data_i), .ch0_de_i(ch0_de_i),
    .ch1_valid_i(ch1_valid_i), .ch1_data_i(ch1_data_i), .ch1_de_i(ch1_de_i),
    .ch2_valid_i(ch2_valid_i), .ch2_data_i(ch2_data_i), .ch2_de_i(ch2_de_i),
    .valid_o(valid_o), .de_o(de_o), .data_o(data_o), .align_err_o(align_err_o)
  );

  logic [W:0]   s0[$], s1[$], s2[$];
  logic [W-1:0] exp_tag_q[$];
  logic [W-1:0] exp_lo_q[$];
  bit           exp_err_q[$];
  int checks = 0, errors = 0, cyc = 0, err_seen = 0;
  bit mon_en = 0, done = 0;

  function automatic logic [W-1:0] tag_of(input int line, input int idx);
    logic [3:0] l;
    l = 4'(line % 14);
    return {l, 6'(idx)};
  endfunction

  function automatic bit over_skew(input int n0, n1, n2, p0, p1, p2);
    int x0, x1, x2, mx, mn;
    x0 = n0 - p0; x1 = n1 - p1; x2 = n2 - p2;
    mx = x0; mn = x0;
    if (x1 > mx) mx = x1;
    if (x2 > mx) mx = x2;
    if (x1 < mn) mn = x1;
    if (x2 < mn) mn = x2;
    return (mx - mn) > SKEW_MAX;
  endfunction

  task automatic check(input bit ok, input string req, input logic [3*W-1:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic put(input int k, input logic de, input logic [W-1:0] v);
    case (k)
      0: s0.push_back({de, v});
      1: s1.push_back({de, v});
      default: s2.push_back({de, v});
    endcase
  endtask

  task automatic finish_sim();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic build_stimulus();
    int d[3], pd[3];
    int b, a;
    bit shrt;
    // R3: active words before any blanking must be discarded
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < 3; k++) put(k, 1'b1, {4'd14, 6'(i)});
    pd = '{0, 0, 0};
    for (int ln = 0; ln < NLINES; ln++) begin
      if (ln == 0)      d = '{0, 0, 0};
      else if (ln == 1) d = '{2, 0, 0};  // R4: spread exactly SKEW_MAX
      else if (ln == 2) d = '{2, 0, 3};  // R5: spread SKEW_MAX+1
      else if (ln == 3) d = '{2, 0, 3};
      else if ($urandom_range(0, 9) < 4)
        for (int k = 0; k < 3; k++) d[k] = $urandom_range(0, MAXD);
      b    = $urandom_range(3, 6);
      a    = $urandom_range(6, 20);
      shrt = (ln % 5 == 4);  // R6: ch1 ends one word early
      for (int k = 0; k < 3; k++) begin
        for (int i = 0; i < b + d[k]; i++) put(k, 1'b0, BLANK);
        for (int i = 0; i < a; i++) begin
          if (shrt && k == 1 && i == a - 1) put(k, 1'b0, BLANK);
          else put(k, 1'b1, tag_of(ln, i));
        end
        for (int i = 0; i < MAXD - d[k]; i++) put(k, 1'b0, BLANK);
      end
      for (int i = 0; i < (shrt ? a - 1 : a); i++) exp_tag_q.push_back(tag_of(ln, i));
      if (shrt) exp_lo_q.push_back(tag_of(ln, a - 1));
      exp_err_q.push_back((ln > 0) && over_skew(d[0], d[1], d[2], pd[0], pd[1], pd[2]));
      pd = d;
    end
    for (int i = 0; i < 24; i++)
      for (int k = 0; k < 3; k++) put(k, 1'b0, BLANK);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected<150000", cyc);
      finish_sim();
    end
  end

  // output monitor, sampled away from the active edge
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (align_err_o) err_seen++;
      if (valid_o && de_o) begin
        if (exp_tag_q.size() == 0) begin
          check(1'b0, "R3 unexpected active word", data_o, '0);
        end else begin
          logic [W-1:0] t;
          t = exp_tag_q.pop_front();
          check(data_o == {t, t, t}, "R2 R7 aligned pixel", data_o, {t, t, t});
          if (t[5:0] == 6'd0) begin
            bit e;
            e = (exp_err_q.size() > 0) ? exp_err_q.pop_front() : 1'b0;
            check(err_seen == int'(e), e ? "R5 error pulse" : "R4 no error",
                  3*W'(err_seen), 3*W'(e));
            err_seen = 0;
          end
        end
      end else if (valid_o && !de_o && exp_lo_q.size() > 0 &&
                   data_o[W-1:0] == exp_lo_q[0]) begin
        logic [W-1:0] t;
        t = exp_lo_q.pop_front();
        check(data_o == {t, BLANK, t}, "R6 de low on partial word", data_o, {t, BLANK, t});
      end
    end
  end

  initial begin
    logic [W:0] w0, w1, w2;
    void'($urandom(32'd20241));
    rst_ni = 1'b0;
    {ch0_valid_i, ch1_valid_i, ch2_valid_i} = '0;
    {ch0_de_i, ch1_de_i, ch2_de_i} = '0;
    ch0_data_i = '0; ch1_data_i = '0; ch2_data_i = '0;
    build_stimulus();
    repeat (3) @(negedge clk_i);
    check({valid_o, de_o, align_err_o} == 3'b000, "R1 in reset",
          3*W'({valid_o, de_o, align_err_o}), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({valid_o, de_o, align_err_o} == 3'b000, "R1 after reset",
          3*W'({valid_o, de_o, align_err_o}), '0);
    mon_en = 1;
    while (s0.size() > 0) begin
      @(negedge clk_i);
      if ($urandom_range(0, 7) == 0) begin
        {ch0_valid_i, ch1_valid_i, ch2_valid_i} = '0;  // R7 idle cycle
        ch0_data_i = '1; ch1_data_i = '1; ch2_data_i = '1;
        {ch0_de_i, ch1_de_i, ch2_de_i} = 3'b111;
      end else begin
        w0 = s0.pop_front(); w1 = s1.pop_front(); w2 = s2.pop_front();
        {ch0_valid_i, ch1_valid_i, ch2_valid_i} = 3'b111;
        ch0_de_i = w0[W]; ch0_data_i = w0[W-1:0];
        ch1_de_i = w1[W]; ch1_data_i = w1[W-1:0];
        ch2_de_i = w2[W]; ch2_data_i = w2[W-1:0];
      end
    end
    @(negedge clk_i);
    {ch0_valid_i, ch1_valid_i, ch2_valid_i} = '0;
    repeat (40) @(negedge clk_i);
    mon_en = 0;
    check(exp_tag_q.size() == 0, "R2 all pixels delivered",
          3*W'(exp_tag_q.size()), '0);
    check(exp_lo_q.size() == 0, "R6 partial words seen",
          3*W'(exp_lo_q.size()), '0);
    check(exp_err_q.size() == 0, "R5 all lines checked",
          3*W'(exp_err_q.size()), '0);
    finish_sim();
  end
endmodule